// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block is a synchronous controller for a 40-bit-wide asynchronous DRAM module with fast page mode. A host issues single-word reads and writes over a valid/ready port with a 20-bit word address. The controller splits that address into a 10-bit row and a 10-bit column. It puts them one after the other on a shared 10-bit address bus and times the active-low row strobe, column strobe, write enable and output enable so that the memory's minimum and maximum pulse widths hold.

After reset the controller waits out the power-up delay. It then runs a burst of refresh cycles in which the column strobe falls before the row strobe, and only after that does it accept host traffic. During normal operation an interval timer asks for one such refresh every 15.6 µs. A pending refresh wins over host requests and first closes any open row. A row stays open after an access, so a later request to the same row needs only a column cycle. A request to another row precharges and reopens, and the row is closed before its low time can reach the page-mode limit. Every timing is a parameter in nanoseconds that is rounded up to whole clock periods.

Top module: `fpm_ctrl`

## Requirements
- R1: Under reset and afterwards, the row strobe, column strobe, write enable and output enable are all high and the host ready is low. The row strobe does not fall until 25000 clocks (200 µs at 8 ns) after reset is released.
- R2: At least 8 refresh cycles (column strobe low before the row strobe falls) complete before the host ready is first asserted.
- R3: For word address A, the row A[19:10] is on the address bus when the row strobe falls and the column A[9:0] is on it when the column strobe falls. A read returns the word last written to the same address.
- R4: The row strobe stays low for at least 8 clocks and high for at least 5 clocks, and two consecutive falls are at least 14 clocks apart.
- R5: The row strobe is never held low for 12500 clocks (100 µs) or more.
- R6: In a refresh the column strobe is low at least 2 clocks before the row strobe falls and stays low at least 2 clocks after it, and write enable stays high.
- R7: In a write, write enable is already low one clock before the column strobe falls, the data bus is driven, and output enable stays high. Output enable is never low while the controller drives the data bus.
- R8: Read data is captured at a clock edge at least 8 clocks after the row strobe fell, at least 2 clocks after the column strobe fell and at least 4 clocks after the column address was applied. The response is valid in the cycle after that edge.
- R9: While a row is open, a request to that row is served with a column cycle only (no new row strobe fall), and two column strobe falls are at least 5 clocks apart.
- R10: A request to a row other than the open one raises the row strobe, meets R4's precharge, and then opens the requested row before its column cycle.
- R11: A refresh request is raised every 1950 clocks. It is served ahead of host requests and closes an open row first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 20 | Word address, row in upper 10 bits |
| req_wdata_i | input | 40 | Write data |
| rsp_valid_o | output | 1 | Read data valid (one-cycle pulse) |
| rsp_rdata_o | output | 40 | Read data |
| dram_addr_o | output | 10 | Multiplexed row/column address |
| dram_ras_no | output | 1 | Row strobe, active low |
| dram_cas_no | output | 1 | Column strobe, active low |
| dram_we_no | output | 1 | Write enable, active low |
| dram_oe_no | output | 1 | Output enable, active low |
| dram_dq_o | output | 40 | Data toward memory |
| dram_dq_oe_o | output | 1 | Data bus drive enable |
| dram_dq_i | input | 40 | Data from memory |

## Verification
A read response is due only after the latest of three distances: 8 clocks from the row strobe fall, 2 from the column strobe fall and 4 from the column address change. It then appears one cycle after the capture edge. The bench records the cycle of every strobe edge and address change and compares each response against those stamps, not against a fixed latency. Strobe pulse widths, precharge, fall-to-fall spacing and refresh setup and hold are measured in the same way from the edge history at each new edge. The refresh rate is checked as a count of refresh cycles over a fixed idle window, and page behaviour is checked as a count of row strobe falls across a run of same-row requests.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [3:0] {
    S_PWR, S_IDLE, S_RSET, S_ACT, S_COL, S_CAS, S_CPRE, S_OPEN, S_CBR_CAS, S_CBR_RAS
  } fpm_state_e;

  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/fpm_age.sv
module fpm_age #(
  parameter int unsigned MAX = 255,
  localparam int unsigned W = $clog2(MAX + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ev_i,
  output logic [W-1:0] age_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 age_o <= W'(MAX);
    else if (ev_i)               age_o <= '0;
    else if (age_o != W'(MAX))   age_o <= age_o + W'(1);
  end
endmodule

// File: rtl/fpm_ref_timer.sv
module fpm_ref_timer #(
  parameter int unsigned PERIOD = 1950,
  localparam int unsigned W = $clog2(PERIOD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  logic [W-1:0] cnt_q;
  logic         tick;

  assign tick = (cnt_q == W'(PERIOD - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + W'(1);
      if (tick)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int unsigned CLK_NS    = 8,
  parameter int unsigned T_PWR_NS  = 200000,
  parameter int unsigned T_REFI_NS = 15600,
  parameter int unsigned T_RP_NS   = 40,
  parameter int unsigned T_RAS_NS  = 60,
  parameter int unsigned T_RC_NS   = 110,
  parameter int unsigned T_PC_NS   = 40,
  parameter int unsigned T_RASP_NS = 100000,
  parameter int unsigned T_CSR_NS  = 10,
  parameter int unsigned T_CHR_NS  = 10,
  parameter int unsigned T_RAH_NS  = 10,
  parameter int unsigned T_RCD_NS  = 20,
  parameter int unsigned T_CAS_NS  = 15,
  parameter int unsigned T_CP_NS   = 10,
  parameter int unsigned T_RAC_NS  = 60,
  parameter int unsigned T_CAC_NS  = 15,
  parameter int unsigned T_AA_NS   = 30,
  parameter int unsigned INIT_REFS = 8,
  parameter int unsigned ROW_W     = 10,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned DATA_W    = 40,
  localparam int unsigned ADDR_W   = ROW_W + COL_W,
  localparam int unsigned MA_W     = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [MA_W-1:0]   dram_addr_o,
  output logic              dram_ras_no,
  output logic              dram_cas_no,
  output logic              dram_we_no,
  output logic              dram_oe_no,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe_o,
  input  logic [DATA_W-1:0] dram_dq_i
);
  localparam logic [31:0] N_PWR    = 32'(ns2cyc(T_PWR_NS, CLK_NS));
  localparam logic [31:0] N_REFI   = 32'(ns2cyc(T_REFI_NS, CLK_NS));
  localparam logic [31:0] N_RP     = 32'(ns2cyc(T_RP_NS, CLK_NS));
  localparam logic [31:0] N_RAS    = 32'(ns2cyc(T_RAS_NS, CLK_NS));
  localparam logic [31:0] N_RC     = 32'(ns2cyc(T_RC_NS, CLK_NS));
  localparam logic [31:0] N_PC     = 32'(ns2cyc(T_PC_NS, CLK_NS));
  localparam logic [31:0] N_RASP   = 32'(ns2cyc(T_RASP_NS, CLK_NS));
  localparam logic [31:0] N_CSR    = 32'(ns2cyc(T_CSR_NS, CLK_NS));
  localparam logic [31:0] N_CHR    = 32'(ns2cyc(T_CHR_NS, CLK_NS));
  localparam logic [31:0] N_RAH    = 32'(ns2cyc(T_RAH_NS, CLK_NS));
  localparam logic [31:0] N_RCD    = 32'(ns2cyc(T_RCD_NS, CLK_NS));
  localparam logic [31:0] N_CAS    = 32'(ns2cyc(T_CAS_NS, CLK_NS));
  localparam logic [31:0] N_CP     = 32'(ns2cyc(T_CP_NS, CLK_NS));
  localparam logic [31:0] N_RAC    = 32'(ns2cyc(T_RAC_NS, CLK_NS));
  localparam logic [31:0] N_CAC    = 32'(ns2cyc(T_CAC_NS, CLK_NS));
  localparam logic [31:0] N_AA     = 32'(ns2cyc(T_AA_NS, CLK_NS));
  localparam logic [31:0] N_CBR_LO = 32'(umax(N_RAS, N_CHR + 1));
  // close an idle page well before the page-mode limit; one access fits in the margin
  localparam logic [31:0] N_PAGE   = N_RASP - 4 * N_RC;
  localparam int unsigned AGE_MAX  = N_RASP;
  localparam int unsigned AW       = $clog2(AGE_MAX + 1);
  localparam int unsigned CNT_W    = $clog2(umax(N_PWR, N_RASP) + 1);
  localparam int unsigned IW       = $clog2(INIT_REFS + 1);
  localparam int unsigned N_AGES   = 4;
  localparam int unsigned A_RFALL  = 0, A_RRISE = 1, A_CFALL = 2, A_COL = 3;

  fpm_state_e        state_q, state_n;
  logic [CNT_W-1:0]  cnt_q;
  logic [IW-1:0]     init_left_q;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept, sample, ref_ack, ref_pend;
  logic [N_AGES-1:0] age_ev;
  logic [AW-1:0]     age [N_AGES];
  logic [31:0]       el, el_rfall, el_rrise, el_cfall, el_col;
  logic              row_hit;

  function automatic logic ras_low_f(fpm_state_e s);
    return s inside {S_ACT, S_COL, S_CAS, S_CPRE, S_OPEN, S_CBR_RAS};
  endfunction

  // elapsed clock periods at the edge closing the current cycle
  assign el       = 32'(cnt_q) + 32'd1;
  assign el_rfall = 32'(age[A_RFALL]) + 32'd1;
  assign el_rrise = 32'(age[A_RRISE]) + 32'd1;
  assign el_cfall = 32'(age[A_CFALL]) + 32'd1;
  assign el_col   = 32'(age[A_COL]) + 32'd1;
  assign row_hit  = (req_addr_i[ADDR_W-1 -: ROW_W] == row_q);

  assign age_ev[A_RFALL] = ras_low_f(state_n) && !ras_low_f(state_q);
  assign age_ev[A_RRISE] = !ras_low_f(state_n) && ras_low_f(state_q);
  assign age_ev[A_CFALL] = (state_n != state_q) && (state_n inside {S_CAS, S_CBR_CAS});
  assign age_ev[A_COL]   = (state_n == S_COL) && (state_q != S_COL);

  for (genvar g = 0; g < N_AGES; g++) begin : g_age
    fpm_age #(.MAX(AGE_MAX)) u_age (
      .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(age_ev[g]), .age_o(age[g])
    );
  end

  fpm_ref_timer #(.PERIOD(N_REFI)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .ack_i(ref_ack), .pend_o(ref_pend)
  );

  always_comb begin
    state_n = state_q;
    accept  = 1'b0;
    sample  = 1'b0;
    ref_ack = 1'b0;
    unique case (state_q)
      S_PWR: if (el >= N_PWR) state_n = S_IDLE;
      S_IDLE: begin
        if (el_rrise >= N_RP && el_rfall >= N_RC) begin
          if (init_left_q != '0 || ref_pend) state_n = S_CBR_CAS;
          else if (req_valid_i) begin
            accept  = 1'b1;
            state_n = S_RSET;
          end
        end
      end
      S_RSET: state_n = S_ACT;
      S_ACT:  if (el >= N_RAH) state_n = S_COL;
      S_COL:  if (el_cfall >= N_PC && el_rfall >= N_RCD) state_n = S_CAS;
      S_CAS: begin
        if (el >= N_CAS && (we_q || (el >= N_CAC && el_col >= N_AA && el_rfall >= N_RAC))) begin
          sample  = !we_q;
          state_n = S_CPRE;
        end
      end
      S_CPRE: if (el >= N_CP) state_n = S_OPEN;
      S_OPEN: begin
        if (ref_pend || el_rfall >= N_PAGE) begin
          if (el_rfall >= N_RAS) state_n = S_IDLE;
        end else if (req_valid_i) begin
          if (row_hit) begin
            accept  = 1'b1;
            state_n = S_COL;
          end else if (el_rfall >= N_RAS) state_n = S_IDLE;
        end
      end
      S_CBR_CAS: if (el >= N_CSR) state_n = S_CBR_RAS;
      S_CBR_RAS: begin
        if (el >= N_CBR_LO) begin
          ref_ack = 1'b1;
          state_n = S_IDLE;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_PWR;
      cnt_q       <= '0;
      init_left_q <= IW'(INIT_REFS);
      row_q       <= '0;
      col_q       <= '0;
      we_q        <= 1'b0;
      wdata_q     <= '0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      state_q     <= state_n;
      rsp_valid_o <= sample;
      if (state_n != state_q)  cnt_q <= '0;
      else if (cnt_q != '1)    cnt_q <= cnt_q + CNT_W'(1);
      if (ref_ack && init_left_q != '0) init_left_q <= init_left_q - IW'(1);
      if (accept) begin
        row_q   <= req_addr_i[ADDR_W-1 -: ROW_W];
        col_q   <= req_addr_i[COL_W-1:0];
        we_q    <= req_we_i;
        wdata_q <= req_wdata_i;
      end
      if (sample) rsp_rdata_o <= dram_dq_i;
    end
  end

  assign req_ready_o  = accept;
  assign dram_ras_no  = !ras_low_f(state_q);
  assign dram_cas_no  = !((state_q inside {S_CAS, S_CBR_CAS}) ||
                          (state_q == S_CBR_RAS && 32'(cnt_q) < N_CHR));
  assign dram_we_no   = !(we_q && (state_q inside {S_COL, S_CAS}));
  assign dram_oe_no   = !(!we_q && state_q == S_CAS);
  assign dram_dq_oe_o = we_q && (state_q inside {S_COL, S_CAS});
  assign dram_dq_o    = wdata_q;
  assign dram_addr_o  = (state_q inside {S_COL, S_CAS, S_CPRE, S_OPEN}) ? MA_W'(col_q) : MA_W'(row_q);
endmodule

// File: rtl/fpm_ctrl_chk.sv
module fpm_ctrl_chk #(
  parameter logic [31:0] N_RAS     = 8,
  parameter logic [31:0] N_RP      = 5,
  parameter logic [31:0] N_RASP    = 12500,
  parameter logic [31:0] INIT_REFS = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic req_ready,
  input logic rsp_valid
);
  logic [31:0] lo_cnt, hi_cnt, cbr_cnt;
  logic        ras_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_cnt  <= '0;
      hi_cnt  <= '0;
      cbr_cnt <= '0;
      ras_q   <= 1'b1;
    end else begin
      ras_q  <= ras_n;
      lo_cnt <= ras_n ? '0 : ((lo_cnt == '1) ? lo_cnt : lo_cnt + 32'd1);
      hi_cnt <= !ras_n ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 32'd1);
      if (ras_q && !ras_n && !cas_n && cbr_cnt != '1) cbr_cnt <= cbr_cnt + 32'd1;
    end
  end

  assert_init_refresh_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready |-> cbr_cnt >= INIT_REFS);
  assert_ras_low_min_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_n) |-> lo_cnt >= N_RAS);
  assert_ras_precharge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_n) |-> hi_cnt >= N_RP);
  assert_page_cap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_n |-> lo_cnt < N_RASP);
  assert_refresh_we_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_n) && !cas_n) |-> we_n);
  assert_early_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_n) && !ras_n && dq_oe) |-> (!we_n && $past(!we_n)));
  assert_no_bus_fight_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dq_oe && !oe_n));
  assert_rsp_after_oe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid |-> $past(!oe_n));
endmodule

bind fpm_ctrl fpm_ctrl_chk #(
  .N_RAS(N_RAS), .N_RP(N_RP), .N_RASP(N_RASP), .INIT_REFS(32'(INIT_REFS))
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_n(dram_ras_no), .cas_n(dram_cas_no),
  .we_n(dram_we_no), .oe_n(dram_oe_no), .dq_oe(dram_dq_oe_o),
  .req_ready(req_ready_o), .rsp_valid(rsp_valid_o)
);

// File: tb/fpm_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpm_ctrl_tb_top;
  localparam longint N_PWR = 25000, N_RP = 5, N_RAS = 8, N_RC = 14, N_PC = 5;
  localparam longint N_RASP = 12500, N_CSR = 2, N_CHR = 2, N_RAC = 8, N_CAC = 2;
  localparam longint N_AA = 4, N_REFI = 1950;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [19:0] req_addr = '0;
  logic [39:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [39:0] rsp_rdata, dq_o, dq_i;
  logic [9:0] ma;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;

  always #4 clk = ~clk;

  fpm_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .dram_addr_o(ma),
    .dram_ras_no(ras_n), .dram_cas_no(cas_n), .dram_we_no(we_n), .dram_oe_no(oe_n),
    .dram_dq_o(dq_o), .dram_dq_oe_o(dq_oe), .dram_dq_i(dq_i)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // memory model and timing monitor
  logic [39:0] mem [int];
  logic [39:0] shadow [int];
  logic [39:0] exp_q [$];
  logic [39:0] rd_word = '0;
  logic [9:0]  row_l = '0;
  longint cyc = 0, rel_cyc = 0, first_fall = -1;
  longint t_rfall = -100000, t_rrise = -100000, t_cfall = -100000, t_col = -100000;
  longint t_cbr_cas = -100000;
  int cbr_cnt = 0, norm_falls = 0;
  bit in_cbr = 1'b0;
  logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
  logic [9:0] p_ma = '0;

  assign dq_i = (!ras_n && !cas_n && !oe_n) ? rd_word : '0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (!ras_n && ma != p_ma) t_col = cyc;
      if (p_ras && !ras_n) begin
        if (first_fall < 0) first_fall = cyc;
        chk(cyc - t_rrise >= N_RP, "R4", "precharge", cyc - t_rrise, N_RP);
        chk(cyc - t_rfall >= N_RC, "R4", "fall spacing", cyc - t_rfall, N_RC);
        if (!cas_n) begin
          cbr_cnt++;
          in_cbr = 1'b1;
          chk(we_n == 1'b1, "R6", "we during refresh", we_n, 1);
          chk(cyc - t_cbr_cas >= N_CSR, "R6", "cas setup", cyc - t_cbr_cas, N_CSR);
        end else begin
          in_cbr = 1'b0;
          norm_falls++;
          row_l = ma;
        end
        t_rfall = cyc;
      end
      if (!p_ras && ras_n) begin
        chk(cyc - t_rfall >= N_RAS, "R4", "ras low", cyc - t_rfall, N_RAS);
        chk(cyc - t_rfall < N_RASP, "R5", "page cap", cyc - t_rfall, N_RASP - 1);
        t_rrise = cyc;
      end
      if (p_cas && !cas_n) begin
        if (ras_n) t_cbr_cas = cyc;
        else begin
          chk(cyc - t_cfall >= N_PC, "R9", "cas spacing", cyc - t_cfall, N_PC);
          if (!we_n) begin
            chk(!p_we && dq_oe && oe_n, "R7", "early write", {p_we, dq_oe, oe_n}, 3'b011);
            mem[int'({row_l, ma})] = dq_o;
          end
          rd_word = mem.exists(int'({row_l, ma})) ? mem[int'({row_l, ma})] : '0;
          t_cfall = cyc;
        end
      end
      if (!p_cas && cas_n && !ras_n && in_cbr)
        chk(cyc - t_rfall >= N_CHR, "R6", "cas hold", cyc - t_rfall, N_CHR);
      if (rsp_valid) begin
        chk(cyc - t_rfall >= N_RAC, "R8", "after ras", cyc - t_rfall, N_RAC);
        chk(cyc - t_cfall >= N_CAC, "R8", "after cas", cyc - t_cfall, N_CAC);
        chk(cyc - t_col >= N_AA, "R8", "after column", cyc - t_col, N_AA);
        if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected response", 1, 0);
        else begin
          logic [39:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R3", "read data", rsp_rdata, e);
        end
      end
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_ma = ma;
  end

  task automatic issue(input bit we, input logic [19:0] a, input logic [39:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    req_valid = 1'b0;
    if (we) shadow[int'(a)] = d;
    else exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : '0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "R1", "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    int f0, c0;
    repeat (3) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n, req_ready} == 5'b11110, "R1", "reset outputs",
        {ras_n, cas_n, we_n, oe_n, req_ready}, 5'b11110);
    rst_n = 1'b1;
    rel_cyc = cyc;
    repeat (10) @(negedge clk);
    chk({ras_n, cas_n, we_n, oe_n, req_ready} == 5'b11110, "R1", "idle after reset",
        {ras_n, cas_n, we_n, oe_n, req_ready}, 5'b11110);

    issue(1'b1, 20'h12345, 40'hA5_5A5A_A5A5);
    chk(first_fall - rel_cyc >= N_PWR, "R1", "power-up wait", first_fall - rel_cyc, N_PWR);
    chk(cbr_cnt >= 8, "R2", "init refreshes", cbr_cnt, 8);
    issue(1'b0, 20'h12345, '0);
    issue(1'b1, 20'hFFFFF, 40'hFF_FFFF_FFFF);
    issue(1'b1, 20'h00000, 40'h00_0000_0001);
    issue(1'b1, 20'hAAAAA, 40'h55_5555_5555);
    issue(1'b0, 20'hFFFFF, '0);
    issue(1'b0, 20'h00000, '0);
    issue(1'b0, 20'hAAAAA, '0);
    issue(1'b0, 20'h54321, '0);
    drain();

    // R9: same-row run right after a refresh
    c0 = cbr_cnt;
    while (cbr_cnt == c0) @(negedge clk);
    repeat (20) @(negedge clk);
    f0 = norm_falls;
    issue(1'b1, {10'd5, 10'd1}, 40'h11_2233_4455);
    issue(1'b1, {10'd5, 10'd2}, 40'h66_7788_99AA);
    issue(1'b1, {10'd5, 10'd3}, 40'hBB_CCDD_EEFF);
    issue(1'b0, {10'd5, 10'd1}, '0);
    issue(1'b0, {10'd5, 10'd3}, '0);
    issue(1'b0, {10'd5, 10'd2}, '0);
    drain();
    chk(norm_falls - f0 == 1, "R9", "row opens in page run", norm_falls - f0, 1);

    // R10: a different row reopens once
    f0 = norm_falls;
    issue(1'b1, {10'd6, 10'd1}, 40'h01_0203_0405);
    issue(1'b0, {10'd6, 10'd1}, '0);
    drain();
    chk(norm_falls - f0 == 1, "R10", "row miss reopen", norm_falls - f0, 1);
    chk(ras_n == 1'b0, "R10", "new row left open", ras_n, 0);

    // R11: refresh rate with an open page at the start of the window
    c0 = cbr_cnt;
    repeat (8000) @(negedge clk);
    chk(cbr_cnt - c0 >= 3 && cbr_cnt - c0 <= 5, "R11", "refreshes in 8000 clocks",
        cbr_cnt - c0, 4);
    issue(1'b0, {10'd6, 10'd1}, '0);
    drain();

    done = 1'b1;
    finish_run();
  end
endmodule